// File: doc/BRIEF.md
# Packed-BCD and Binary Add/Subtract Unit

This unit is the arithmetic stage of a small CPU core. It adds with carry or subtracts with borrow on two operand bytes. It works either in plain two's-complement binary or on packed decimal operands that hold two BCD digits each. It returns the result byte and four condition flags: negative, signed overflow, zero and carry. All outputs come from registers, and a `done` pulse marks each new result.

A variant select picks how decimal mode reports its flags.

- **Legacy variant:** negative, overflow and zero are taken from the binary sum or difference before decimal correction. Only the carry follows the decimal result. The result is ready one clock after the request.
- **Corrected variant:** all four flags come from the corrected decimal result. This costs one extra clock, during which `busy` is high and further requests are ignored.
- **Binary mode:** behaves the same in both variants.

Top module: `bcd_addsub_unit`

## Requirements
- R1: Binary add (dec_mode=0, subtract=0) gives result = (A + M + carry_in) mod 256 and C = 1 exactly when that sum exceeds 255.
- R2: Binary subtract (dec_mode=0, subtract=1) gives result = (A − M − (1 − carry_in)) mod 256 and C = 1 exactly when that difference is not negative; the carry acts as an inverted borrow.
- R3: In binary mode N = result bit 7, Z = 1 when all 8 result bits are 0, and V = 1 when the signed (two's-complement) value of the operation lies outside −128..127.
- R4: Decimal add (dec_mode=1, subtract=0) on valid packed BCD operands (high digit in bits 7:4, low digit in bits 3:0) gives the packed BCD of (A + M + carry_in) mod 100, with C = 1 when that decimal sum exceeds 99.
- R5: Decimal subtract on valid packed BCD operands gives the packed BCD of (A − M − (1 − carry_in)) mod 100, with C = 1 when the decimal difference is not negative.
- R6: With fixed_flags=0 and dec_mode=1, N, V and Z equal the values the same operation would give in binary mode, while C and the result follow R4/R5.
- R7: With fixed_flags=1 and dec_mode=1, N = result bit 7, Z = (result == 0), and V = 1 when bit 7 of A equals bit 7 of the second operand (M for add, ~M for subtract) and result bit 7 differs from bit 7 of A.
- R8: A request taken in cycle k raises done after edge k+1, except the corrected decimal case: busy is high after edge k+1 and done after edge k+2, then busy is low again.
- R9: A start while busy is high is ignored, and result and flags change only on a cycle in which done rises.
- R10: While rst is high, result, flags, done and busy are all 0.
- R11: In binary mode fixed_flags has no effect: the same result, flags and one-cycle latency as with fixed_flags=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, one cycle per operation |
| op_a | input | 8 | First operand (accumulator side) |
| op_m | input | 8 | Second operand (memory side) |
| carry_in | input | 1 | Carry in; inverted borrow for subtract |
| dec_mode | input | 1 | 1 selects packed BCD arithmetic |
| subtract | input | 1 | 1 selects subtract, 0 add |
| fixed_flags | input | 1 | 1 selects corrected decimal flags with one extra cycle |
| result | output | 8 | Registered result byte |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| done | output | 1 | One-cycle pulse when a new result is presented |
| busy | output | 1 | High during the added cycle of the corrected decimal path |

## Verification
The in-RTL properties check the timing on every cycle:
- the single-cycle busy window and the done that always follows it;
- the one-cycle latency of every other request;
- that result never moves without done;
- the reset state;
- the N and Z coherence of results that leave the corrected path.

The arithmetic itself can only be shown by the bench sweeps, which compare every result and flag against integer arithmetic. These cover:
- all of A with a strided M in binary mode;
- every valid BCD A with strided valid BCD M in both decimal variants;
- both carries and both operations throughout.

That the legacy flags follow the binary value, and that a start during busy is dropped, likewise show only in those scenarios.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } alu_flags_t;

  // Two's-complement overflow from the sign bits of both addends and the sum.
  function automatic logic sign_overflow(input logic a_msb, input logic op_msb,
                                         input logic r_msb);
    return (a_msb == op_msb) && (r_msb != a_msb);
  endfunction
endpackage

// File: rtl/addsub_binary.sv
module addsub_binary #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] m,
  input  logic             cin,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);
  import addsub_pkg::*;

  logic [WIDTH-1:0] op2;
  logic [WIDTH:0]   full;

  always_comb begin
    op2  = sub ? ~m : m;
    full = {1'b0, a} + {1'b0, op2} + (WIDTH+1)'(cin);
    sum  = full[WIDTH-1:0];
    cout = full[WIDTH];
    ovf  = sign_overflow(a[WIDTH-1], op2[WIDTH-1], full[WIDTH-1]);
  end
endmodule

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage (
  input  logic [3:0] a_dig,
  input  logic [3:0] m_dig,
  input  logic       cin,
  input  logic       sub,
  output logic [3:0] d_out,
  output logic       cout
);
  logic [4:0] t;

  always_comb begin
    if (!sub) begin
      t = {1'b0, a_dig} + {1'b0, m_dig} + 5'(cin);
      if (t > 5'd9) begin
        d_out = t[3:0] + 4'd6;
        cout  = 1'b1;
      end else begin
        d_out = t[3:0];
        cout  = 1'b0;
      end
    end else begin
      t = {1'b0, a_dig} - {1'b0, m_dig} - 5'(!cin);
      if (t[4]) begin
        d_out = t[3:0] - 4'd6;
        cout  = 1'b0;
      end else begin
        d_out = t[3:0];
        cout  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/addsub_bcd.sv
module addsub_bcd #(
  parameter int DIGITS = 2
) (
  input  logic [4*DIGITS-1:0] a,
  input  logic [4*DIGITS-1:0] m,
  input  logic                cin,
  input  logic                sub,
  output logic [4*DIGITS-1:0] sum,
  output logic                cout
);
  logic [DIGITS:0] chain;

  assign chain[0] = cin;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    bcd_digit_stage u_dig (
      .a_dig (a[4*g +: 4]),
      .m_dig (m[4*g +: 4]),
      .cin   (chain[g]),
      .sub   (sub),
      .d_out (sum[4*g +: 4]),
      .cout  (chain[g+1])
    );
  end

  assign cout = chain[DIGITS];
endmodule

// File: rtl/bcd_addsub_unit.sv
module bcd_addsub_unit #(
  parameter int DIGITS = 2,
  localparam int WIDTH = 4 * DIGITS,
  localparam int MSB   = WIDTH - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_m,
  input  logic             carry_in,
  input  logic             dec_mode,
  input  logic             subtract,
  input  logic             fixed_flags,
  output logic [WIDTH-1:0] result,
  output logic             flag_n,
  output logic             flag_v,
  output logic             flag_z,
  output logic             flag_c,
  output logic             done,
  output logic             busy
);
  import addsub_pkg::*;

  logic [WIDTH-1:0] bin_sum, dec_sum;
  logic             bin_c, bin_v, dec_c;

  addsub_binary #(.WIDTH(WIDTH)) u_bin (
    .a(op_a), .m(op_m), .cin(carry_in), .sub(subtract),
    .sum(bin_sum), .cout(bin_c), .ovf(bin_v)
  );

  addsub_bcd #(.DIGITS(DIGITS)) u_bcd (
    .a(op_a), .m(op_m), .cin(carry_in), .sub(subtract),
    .sum(dec_sum), .cout(dec_c)
  );

  // Staging for the corrected decimal path
  logic [WIDTH-1:0] hold_res;
  logic             hold_c, hold_a_msb, hold_op_msb;
  logic             accept, take_long;
  alu_flags_t       flg_q, quick_flags;
  logic [WIDTH-1:0] quick_res;

  always_comb begin
    accept    = start && !busy;
    take_long = dec_mode && fixed_flags;
    quick_res = dec_mode ? dec_sum : bin_sum;
    // Legacy decimal flags come from the binary value; carry is decimal.
    quick_flags.n = bin_sum[MSB];
    quick_flags.v = bin_v;
    quick_flags.z = (bin_sum == '0);
    quick_flags.c = dec_mode ? dec_c : bin_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result      <= '0;
      flg_q       <= '0;
      done        <= 1'b0;
      busy        <= 1'b0;
      hold_res    <= '0;
      hold_c      <= 1'b0;
      hold_a_msb  <= 1'b0;
      hold_op_msb <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        result  <= hold_res;
        flg_q.n <= hold_res[MSB];
        flg_q.z <= (hold_res == '0);
        flg_q.c <= hold_c;
        flg_q.v <= sign_overflow(hold_a_msb, hold_op_msb, hold_res[MSB]);
        done    <= 1'b1;
        busy    <= 1'b0;
      end else if (accept) begin
        if (take_long) begin
          hold_res    <= dec_sum;
          hold_c      <= dec_c;
          hold_a_msb  <= op_a[MSB];
          hold_op_msb <= subtract ? ~op_m[MSB] : op_m[MSB];
          busy        <= 1'b1;
        end else begin
          result <= quick_res;
          flg_q  <= quick_flags;
          done   <= 1'b1;
        end
      end
    end
  end

  assign flag_n = flg_q.n;
  assign flag_v = flg_q.v;
  assign flag_z = flg_q.z;
  assign flag_c = flg_q.c;

  // R8
  busy_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy && done));

  // R8
  quick_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !(dec_mode && fixed_flags)) |=> (done && !busy));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

  // R7
  fixed_nz_chk: assert property (@(posedge clk) disable iff (rst)
    (done && $past(busy)) |-> (flag_n == result[MSB] && flag_z == (result == '0)));

  // R10
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!done && !busy && result == '0));
endmodule

// File: tb/test_bcd_addsub_unit.sv
module test_bcd_addsub_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] op_a = '0, op_m = '0;
  logic       carry_in = 1'b0, dec_mode = 1'b0, subtract = 1'b0, fixed_flags = 1'b0;
  logic [7:0] result;
  logic       flag_n, flag_v, flag_z, flag_c, done, busy;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  bcd_addsub_unit i_bcd_addsub_unit (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_m(op_m),
    .carry_in(carry_in), .dec_mode(dec_mode), .subtract(subtract),
    .fixed_flags(fixed_flags), .result(result), .flag_n(flag_n),
    .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c), .done(done), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int to_bcd(input int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  // Binary reference: returns {n,v,z,c} and result through out args
  task automatic bin_ref(input int a, input int m, input int c, input bit sb,
                         output int res, output int fl);
    int full, sa, sm, sv;
    sa = (a > 127) ? a - 256 : a;
    sm = (m > 127) ? m - 256 : m;
    if (!sb) begin
      full = a + m + c;
      sv   = sa + sm + c;
    end else begin
      full = a - m - (1 - c);
      sv   = sa - sm - (1 - c);
    end
    res = full & 255;
    fl  = ((res >> 7) << 3) | (((sv < -128) || (sv > 127)) ? 4 : 0) |
          ((res == 0) ? 2 : 0) | (sb ? ((full >= 0) ? 1 : 0) : ((full > 255) ? 1 : 0));
  endtask

  task automatic run_op(input int a, input int m, input int c, input bit sb,
                        input bit dm, input bit fx);
    int bres, bfl, exp_res, exp_fl, dv, da, dmv, exp_c, av, opm7, r7;
    string rtag, ftag;
    bit   long_path;
    logic [3:0] got_fl;
    bin_ref(a, m, c, sb, bres, bfl);
    long_path = dm && fx;
    if (!dm) begin
      exp_res = bres;
      exp_fl  = bfl;
      rtag    = sb ? "R2" : "R1";
      ftag    = fx ? "R11 flags" : "R3 flags";
    end else begin
      da  = (a >> 4) * 10 + (a & 15);
      dmv = (m >> 4) * 10 + (m & 15);
      if (!sb) begin
        dv = da + dmv + c;
        exp_c = (dv > 99) ? 1 : 0;
        dv = dv % 100;
      end else begin
        dv = da - dmv - (1 - c);
        exp_c = (dv >= 0) ? 1 : 0;
        if (dv < 0) dv += 100;
      end
      exp_res = to_bcd(dv);
      rtag = sb ? "R5" : "R4";
      if (!fx) begin
        exp_fl = (bfl & 14) | exp_c;
        ftag   = "R6 flags";
      end else begin
        av   = (a >> 7) & 1;
        opm7 = sb ? (((m >> 7) & 1) ^ 1) : ((m >> 7) & 1);
        r7   = (exp_res >> 7) & 1;
        exp_fl = (r7 << 3) | (((av == opm7) && (r7 != av)) ? 4 : 0) |
                 ((exp_res == 0) ? 2 : 0) | exp_c;
        ftag = "R7 flags";
      end
    end
    @(negedge clk);
    op_a = 8'(a); op_m = 8'(m); carry_in = 1'(c); subtract = sb;
    dec_mode = dm; fixed_flags = fx; start = 1'b1;
    @(negedge clk);
    if (long_path) begin
      // R8: extra cycle, busy high, no done yet
      chk(busy && !done, "R8 busy window", {busy, done}, 2);
      // R9: a request during busy must be dropped
      op_a = 8'(~a); op_m = 8'(a); subtract = ~sb;
      @(negedge clk);
      start = 1'b0;
    end else begin
      start = 1'b0;
    end
    chk(done && !busy, fx ? "R11 latency" : "R8 latency", {done, busy}, 2);
    chk(result == 8'(exp_res), long_path ? "R9 R4/R5 result" : rtag, result, exp_res);
    got_fl = {flag_n, flag_v, flag_z, flag_c};
    chk(got_fl == 4'(exp_fl), ftag, got_fl, exp_fl);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!done && !busy && result == 0 &&
        {flag_n, flag_v, flag_z, flag_c} == 4'b0, "R10 reset", result, 0);
    rst = 1'b0;

    // Binary sweep, both variants interleaved by a[0] (R1 R2 R3 R11)
    for (int a = 0; a < 256; a++)
      for (int m = 0; m < 256; m += 7)
        for (int c = 0; c < 2; c++)
          for (int s = 0; s < 2; s++)
            run_op(a, m, c, 1'(s), 1'b0, 1'(a & 1));

    // Legacy decimal sweep (R4 R5 R6)
    for (int x = 0; x < 100; x++)
      for (int y = 0; y < 100; y += 2)
        for (int c = 0; c < 2; c++)
          for (int s = 0; s < 2; s++)
            run_op(to_bcd(x), to_bcd(y), c, 1'(s), 1'b1, 1'b0);

    // Corrected decimal sweep (R4 R5 R7 R8 R9)
    for (int x = 0; x < 100; x++)
      for (int y = 0; y < 100; y += 3)
        for (int c = 0; c < 2; c++)
          for (int s = 0; s < 2; s++)
            run_op(to_bcd(x), to_bcd(y), c, 1'(s), 1'b1, 1'b1);

    // Corner cases: 99+0+1, 00-00-borrow, 99+99+1
    run_op(8'h99, 8'h00, 1, 1'b0, 1'b1, 1'b1);
    run_op(8'h00, 8'h00, 0, 1'b1, 1'b1, 1'b1);
    run_op(8'h99, 8'h99, 1, 1'b0, 1'b1, 1'b0);

    @(negedge clk);
    // R9: ignored request left no trailing done
    chk(!done, "R9 no stray done", done, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule